// File: doc/BRIEF.md
# Word-Boundary Uplink Priority Merger

This block is the 32-bit stage of a low-speed serial camera uplink transmitter. It takes a valid/ready stream of already-wrapped packet words and merges two more urgent items into it: a single-word trigger-acknowledge marker and a periodic idle word. Inserted words only ever go between whole 32-bit words. Every word carries a 4-bit control flag, with bit i set when byte i (bits 8i+7:8i, byte 0 sent first) is a control character. The merged stream leaves on a 32-bit valid/ready port toward a word-to-byte converter.

Back-pressure works like this. The output register is loaded whenever it is empty or the downstream accepts its word. When the output is stalled, the word it holds stays frozen and `in_ready` is low. `in_ready` is also low in any slot that an inserted word claims, so a data word is never dropped or repeated. When the upstream has nothing valid, the free slot is filled with an idle word. After reset the output therefore carries a continuous word stream.

A one-cycle strobe requests an acknowledge. The request is held in a pending flag until the next free word slot. A strobe that arrives while a request is already pending joins it, so only one acknowledge word goes out for both.

Top module: `uplink_word_merger`

## Requirements
- R1: While `rst_n` is low, `out_valid` is low. With no upstream input, the first word after reset is an idle word.
- R2: The acknowledge word is 32'h01DCDCDC with flags 4'b0111. A pending acknowledge takes the next free slot ahead of both idle and data words.
- R3: The idle word is 32'hB53C3CBC with flags 4'b0111 (K28.5, K28.1, K28.1, D21.5 from byte 0 upward). It fills every free slot in which `in_valid` is low and no acknowledge is pending.
- R4: At most IDLE_INTERVAL-1 data words go out between two idle words. The interval count restarts whenever an idle word is emitted. An uninterrupted data stream gets exactly IDLE_INTERVAL-1 words per idle.
- R5: An `ack_req` strobe is served two clock edges later if the output is free. Strobes that arrive while a request is pending produce one acknowledge word in total.
- R6: `in_ready` is low when the output is stalled or an inserted word owns the slot. Data words leave in arrival order, with none lost or duplicated.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_ctrl` hold their values.
- R8: A data word keeps its data and its flags unchanged, for example 32'hFBFBFBFB with flags 4'b1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ack_req | input | 1 | One-cycle trigger-acknowledge request strobe |
| in_valid | input | 1 | Upstream word valid |
| in_ready | output | 1 | Upstream word accepted this cycle |
| in_data | input | 32 | Upstream word |
| in_ctrl | input | 4 | Upstream per-byte control flags |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts output word |
| out_data | output | 32 | Merged output word |
| out_ctrl | output | 4 | Per-byte control flags of the output word |

## Verification
Several rules are checked by assertions on every cycle:
- the output word stays frozen while it is stalled;
- `in_ready` is low while the output is stalled;
- an accepted word appears unchanged on the next output;
- a pending acknowledge wins the next slot;
- a request always becomes pending;
- the data-word count since the last idle never reaches the interval.

Other properties need whole sequences and are shown only by the bench scenarios:
- data order under randomly stalled streams on both sides;
- exactly one acknowledge word for each strobe, and one for a merged pair;
- the exact period of the idle word in a continuous stream;
- the two-edge acknowledge latency.

// File: rtl/uplink_merge_pkg.sv
package uplink_merge_pkg;
  localparam int WORD_W = 32;
  localparam int BYTES  = WORD_W / 8;

  typedef enum logic [1:0] {
    SRC_DATA = 2'd0,
    SRC_IDLE = 2'd1,
    SRC_ACK  = 2'd2
  } src_e;

  // byte 0 = bits 7:0, sent first
  localparam logic [WORD_W-1:0] IDLE_WORD = 32'hB53C3CBC;
  localparam logic [BYTES-1:0]  IDLE_CTRL = 4'b0111;
  localparam logic [WORD_W-1:0] ACK_WORD  = 32'h01DCDCDC;
  localparam logic [BYTES-1:0]  ACK_CTRL  = 4'b0111;
endpackage

// File: rtl/uplink_ack_latch.sv
module uplink_ack_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_req,
  input  logic take,
  output logic pend
);
  // a new strobe wins over the clear caused by serving an older one
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= ack_req | (pend & ~take);
  end

  p_req_pends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> pend);
  p_take_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && take && !ack_req) |=> !pend);
endmodule

// File: rtl/uplink_idle_pacer.sv
module uplink_idle_pacer
  import uplink_merge_pkg::*;
#(
  parameter int INTERVAL = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slot,
  input  src_e sel,
  output logic idle_due
);
  localparam int CNT_W = $clog2(INTERVAL);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt;

  // counts non-idle words loaded since the last idle; saturates at LAST
  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (slot) begin
      if (sel == SRC_IDLE)  cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
    end
  end

  assign idle_due = (cnt == LAST);

  p_idle_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot && sel == SRC_IDLE) |=> !idle_due);
endmodule

// File: rtl/uplink_out_stage.sv
module uplink_out_stage
  import uplink_merge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  src_e              sel,
  input  logic [WORD_W-1:0] in_data,
  input  logic [BYTES-1:0]  in_ctrl,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic [BYTES-1:0]  out_ctrl,
  output logic              slot
);
  assign slot = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ctrl  <= '0;
    end else if (slot) begin
      out_valid <= 1'b1;
      unique case (sel)
        SRC_ACK:  begin out_data <= ACK_WORD;  out_ctrl <= ACK_CTRL;  end
        SRC_IDLE: begin out_data <= IDLE_WORD; out_ctrl <= IDLE_CTRL; end
        default:  begin out_data <= in_data;   out_ctrl <= in_ctrl;   end
      endcase
    end
  end

  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ctrl)));
endmodule

// File: rtl/uplink_word_merger.sv
module uplink_word_merger
  import uplink_merge_pkg::*;
#(
  parameter int IDLE_INTERVAL = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_req,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic [BYTES-1:0]  in_ctrl,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic [BYTES-1:0]  out_ctrl
);
  localparam int GAP_W = $clog2(IDLE_INTERVAL) + 1;

  logic ack_pend, idle_due, slot;
  src_e sel;

  // fixed priority: acknowledge, then idle (due or filler), then data
  always_comb begin
    if (ack_pend)                   sel = SRC_ACK;
    else if (idle_due || !in_valid) sel = SRC_IDLE;
    else                            sel = SRC_DATA;
  end

  assign in_ready = slot && !ack_pend && !idle_due;

  uplink_ack_latch u_ack (
    .clk(clk), .rst_n(rst_n), .ack_req(ack_req),
    .take(slot && ack_pend), .pend(ack_pend)
  );

  uplink_idle_pacer #(.INTERVAL(IDLE_INTERVAL)) u_pacer (
    .clk(clk), .rst_n(rst_n), .slot(slot), .sel(sel), .idle_due(idle_due)
  );

  uplink_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .sel(sel), .in_data(in_data), .in_ctrl(in_ctrl),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ctrl(out_ctrl), .slot(slot)
  );

  // independent count of data words loaded since the last idle word
  logic [GAP_W-1:0] chk_gap;
  always_ff @(posedge clk) begin
    if (!rst_n) chk_gap <= '0;
    else if (slot) begin
      if (sel == SRC_IDLE)      chk_gap <= '0;
      else if (sel == SRC_DATA) chk_gap <= chk_gap + 1'b1;
    end
  end

  p_idle_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_gap < GAP_W'(IDLE_INTERVAL));
  p_ack_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_pend && slot) |=> (out_data == ACK_WORD && out_ctrl == ACK_CTRL));
  p_pass_through_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_data == $past(in_data) && out_ctrl == $past(in_ctrl)));
  p_no_take_stalled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

// File: tb/test_uplink_word_merger.sv
module test_uplink_word_merger;
  localparam int CLK_PERIOD = 10;
  localparam int IVL = 16;
  localparam logic [31:0] IDLE_W = 32'hB53C3CBC;
  localparam logic [31:0] ACK_W  = 32'h01DCDCDC;

  logic clk = 1'b0, rst_n = 1'b0, ack_req = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [31:0] in_data = '0, out_data;
  logic [3:0]  in_ctrl = '0, out_ctrl;

  int errors = 0, checks = 0;
  int n_ack = 0, n_idle = 0, n_data = 0, gap = 0, max_gap = 0, mism = 0;
  int rdy_mode = 0;
  logic [35:0] expq[$];

  uplink_word_merger #(.IDLE_INTERVAL(IVL)) i_uplink_word_merger (
    .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_ctrl(in_ctrl),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_ctrl(out_ctrl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // output monitor: a transfer happens at the next posedge
  always begin
    @(negedge clk); #1;
    if (rst_n && out_valid && out_ready) begin
      if (out_data == ACK_W && out_ctrl == 4'b0111) n_ack++;
      else if (out_data == IDLE_W && out_ctrl == 4'b0111) begin n_idle++; gap = 0; end
      else begin
        n_data++; gap++;
        if (gap > max_gap) max_gap = gap;
        if (expq.size() == 0) mism++;
        else if (expq.pop_front() != {out_ctrl, out_data}) mism++;
      end
    end
  end

  always begin
    @(negedge clk);
    out_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? (($urandom % 3) != 0) : 1'b0;
  end

  task automatic clear_counts();
    n_ack = 0; n_idle = 0; n_data = 0; max_gap = 0; gap = 0; mism = 0;
  endtask

  task automatic send_word(input logic [31:0] d, input logic [3:0] c);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_ctrl = c;
    forever begin
      #2;
      if (in_ready) break;
      @(negedge clk);
    end
    expq.push_back({c, d});
  endtask

  task automatic send_words(input int n, input int base, input bit stall);
    for (int i = 0; i < n; i++) begin
      if (stall && ($urandom % 4) == 0) begin
        @(negedge clk); in_valid = 1'b0;
      end
      send_word(32'h1000_0000 + base + i, 4'b0000);
    end
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack_req = 1'b1;
    @(negedge clk); ack_req = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    wait_cycles(3); #1;
    check(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    check(out_valid == 1'b1, "R1 first valid", out_valid, 1);
    check(out_data == IDLE_W, "R1 first word idle", out_data, IDLE_W);
    check(out_ctrl == 4'b0111, "R3 idle flags", out_ctrl, 4'b0111);
  endtask

  task automatic t_idle_fill();
    clear_counts();
    wait_cycles(20);
    check(n_idle >= 19, "R3 idle fill count", n_idle, 19);
    check(n_data == 0 && n_ack == 0, "R3 no other words", n_data + n_ack, 0);
  endtask

  task automatic t_interval();
    clear_counts();
    send_words(48, 0, 1'b0);
    wait_cycles(5);
    check(max_gap == IVL - 1, "R4 exact interval", max_gap, IVL - 1);
    check(n_idle >= 3, "R4 idle count", n_idle, 3);
    check(mism == 0 && expq.size() == 0 && n_data == 48, "R6 order no loss", n_data, 48);
  endtask

  task automatic t_ack_latency();
    wait_cycles(2);
    @(negedge clk); ack_req = 1'b1;
    @(negedge clk); ack_req = 1'b0; #1;
    check(out_data != ACK_W, "R5 not before two edges", out_data, IDLE_W);
    @(negedge clk); #1;
    check(out_data == ACK_W && out_ctrl == 4'b0111, "R2 ack word encoding", out_data, ACK_W);
    @(negedge clk); #1;
    check(out_data == IDLE_W, "R5 single ack then idle", out_data, IDLE_W);
  endtask

  task automatic t_ack_merge();
    logic [31:0] held;
    clear_counts();
    rdy_mode = 2;
    wait_cycles(2); #1;
    held = out_data;
    pulse_ack(); pulse_ack(); pulse_ack();
    #1;
    check(out_data == held && out_valid, "R7 stalled word held", out_data, held);
    check(in_ready == 1'b0, "R6 no accept when stalled", in_ready, 0);
    rdy_mode = 0;
    wait_cycles(6);
    check(n_ack == 1, "R5 merged strobes one ack", n_ack, 1);
  endtask

  task automatic t_ack_priority();
    clear_counts();
    fork
      send_words(30, 100, 1'b0);
      begin
        for (int k = 0; k < 3; k++) begin wait_cycles(6); pulse_ack(); end
      end
    join
    wait_cycles(5);
    check(n_ack == 3, "R2 ack among data", n_ack, 3);
    check(mism == 0 && expq.size() == 0, "R6 order with acks", mism, 0);
    check(max_gap <= IVL - 1, "R4 gap with acks", max_gap, IVL - 1);
  endtask

  task automatic t_random();
    clear_counts();
    rdy_mode = 1;
    fork
      send_words(200, 1000, 1'b1);
      begin
        for (int k = 0; k < 6; k++) begin wait_cycles(20); pulse_ack(); end
      end
    join
    rdy_mode = 0;
    wait_cycles(10);
    check(n_ack == 6, "R5 one ack per strobe", n_ack, 6);
    check(mism == 0 && expq.size() == 0 && n_data == 200, "R6 random order", n_data, 200);
    check(max_gap <= IVL - 1, "R4 random gap", max_gap, IVL - 1);
  endtask

  task automatic t_ctrl_pass();
    clear_counts();
    send_word(32'hFBFBFBFB, 4'b1111);
    @(negedge clk); in_valid = 1'b0;
    wait_cycles(4);
    check(n_data == 1 && mism == 0, "R8 start marker passes", mism, 0);
  endtask

  initial begin
    t_reset();
    t_idle_fill();
    t_interval();
    t_ack_latency();
    t_ack_merge();
    t_ack_priority();
    t_random();
    t_ctrl_pass();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule